// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block runs the receive side of one DMA channel over a ring of four-word descriptors held in system memory. Software fills descriptors, hands them over by setting an ownership flag, and moves a tail index forward. While a received packet is waiting, the engine compares the tail index with its own current index. If they differ, it reads the descriptor at the current slot and checks that the slot is owned by the engine and that its two buffer pointers are usable. It then passes up to two buffers, each with a byte count, to the packet data path.

When the descriptor's buffers are full or the packet ends, the engine writes the descriptor's status word back. That word has ownership cleared, first and last flags, and, on the last descriptor only, the packet length and an error summary. A packet that carries a timestamp also takes the following ring slot: the engine overwrites that slot as a context record holding the 64-bit timestamp. A descriptor whose two buffer pointers are both all ones is a definition error. The engine closes it with a three-flag code, drops the packet and stops until a software reset.

Top module: `rdr_ring_engine`

## Requirements
- R1: After reset no memory request, interrupt, stop or empty indication is active and the current index is 0. A descriptor is read only when the tail index differs from the current index. While a packet waits and the two indices are equal, `no_desc` is 1 and no memory request is made.
- R2: A descriptor is used only if bit 31 of its word 3 is 1. Otherwise no buffer is handed out, nothing is written, `no_desc` stays 1, and the slot is read again only after `tail_idx` changes.
- R3: `irq` pulses for one cycle after the write-back of a descriptor whose word 3 bit 30 was 1. A descriptor with that bit at 0 raises no pulse.
- R4: A buffer whose address (word 0 for the first buffer, word 2 for the second) is zero gets no data. The engine goes on to the other buffer or to the next descriptor.
- R5: If both buffer addresses are 0xFFFFFFFF, word 3 is written as 0x70000000 (bits 30, 29 and 28 set, bit 31 clear). The packet is dropped with a `pkt_done` pulse and the current index does not move. `halted` goes to 1 and there are no further memory requests until `sw_rst`, which clears `halted` and sets the current index to 0.
- R6: On a normal write-back, word 3 has bit 31 = 0 and bit 30 = 0. Bit 29 is set when this descriptor received the first bytes of the packet, and bit 28 when it holds the end of the packet. Bits 13:0 carry the packet length and bit 15 the packet error flag, both only on the last descriptor and zero otherwise.
- R7: For a packet with `pkt_ts_valid`, bit 27 of the last descriptor's word 3 is set. The next slot is then written with the timestamp (word 0 = bits 31:0, word 1 = bits 63:32) and with word 3 = 0x40000010 (bit 30 context, bit 4 timestamp present). That slot's buffers are never used and its word 2 stays unchanged.
- R8: Each buffer receives at most `BUF_BYTES` bytes. A longer packet continues in the following descriptors, and bit 29 is clear on those.
- R9: After slot `ring_len-1` the current index returns to 0.
- R10: Slot i lies at `ring_base + 16*i`, and word k of a slot lies 4*k above that. Only word 3 of a normal descriptor is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset, leaves the stopped state |
| ring_base | input | AW | Byte address of slot 0 (16-byte aligned) |
| ring_len | input | IW | Number of slots in the ring |
| tail_idx | input | IW | Software tail index |
| cur_idx | output | IW | Current slot index |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion of the current access |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| pkt_valid | input | 1 | A received packet is waiting, held until `pkt_done` |
| pkt_len | input | PLEN_W | Packet length in bytes |
| pkt_err | input | 1 | Packet error summary |
| pkt_ts_valid | input | 1 | Packet carries a timestamp |
| pkt_ts | input | 64 | Packet timestamp |
| pkt_done | output | 1 | Packet fully placed or dropped |
| buf_valid | output | 1 | Hand one buffer to the data path |
| buf_addr | output | AW | Buffer address |
| buf_len | output | PLEN_W | Bytes to place in that buffer |
| irq | output | 1 | Completion interrupt pulse |
| no_desc | output | 1 | Packet waiting but no usable slot |
| halted | output | 1 | Stopped on a descriptor definition error |

## Verification
Two things can happen on the same write-back acknowledge: the current index wraps from the last slot to slot 0, and the packet's timestamp spills into the next slot. To provoke this, the bench places a timestamped packet in the last ring slot, whose ownership flag is first left clear and set only after a tail update. It then checks that the context record lands in slot 0 with that slot's buffer word untouched, and that the index ends at 1. Ownership refusal followed by release through a tail change is judged in the same scenario, from `no_desc`, the buffer log and memory contents.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  // word 3 bit positions shared by fetch decode and write-back
  localparam int unsigned OWN_B = 31;
  localparam int unsigned IOC_B = 30;
  localparam int unsigned CTX_B = 30;
  localparam int unsigned FD_B  = 29;
  localparam int unsigned LD_B  = 28;
  localparam int unsigned CDA_B = 27;
  localparam int unsigned ES_B  = 15;
  localparam int unsigned TSA_B = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_EVAL, S_DELIV, S_WB, S_CTXW, S_CTX, S_HALT
  } rdr_state_e;

  typedef enum logic [1:0] {WK_NORM, WK_BAD, WK_CTX} wb_kind_e;
endpackage

// File: rtl/rdr_ring_ptr.sv
module rdr_ring_ptr #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic [AW-1:0] ring_base,
  input  logic [IW-1:0] ring_len,
  input  logic [IW-1:0] tail,
  input  logic          adv,
  input  logic          mark_stall,
  output logic [IW-1:0] cur,
  output logic [AW-1:0] slot_addr,
  output logic          avail
);
  localparam int unsigned SLOT_SH = 4;

  logic [IW-1:0] cur_q, cur_d, tail_q;
  logic          stall_q, stall_d;

  always_comb begin
    cur_d = cur_q;
    if (adv) cur_d = (cur_q == ring_len - 1'b1) ? '0 : cur_q + 1'b1;
    stall_d = stall_q;
    if (tail != tail_q)  stall_d = 1'b0;
    else if (mark_stall) stall_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      tail_q  <= '0;
      stall_q <= 1'b0;
    end else if (sw_rst) begin
      cur_q   <= '0;
      tail_q  <= tail;
      stall_q <= 1'b0;
    end else begin
      cur_q   <= cur_d;
      tail_q  <= tail;
      stall_q <= stall_d;
    end
  end

  assign cur       = cur_q;
  assign slot_addr = ring_base + AW'({cur_q, {SLOT_SH{1'b0}}});
  assign avail     = (cur_q != tail) && !stall_q;

  // R9: an advance either steps by one or wraps to slot 0
  a_r9_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sw_rst) |=> (cur_q == '0) || (cur_q == $past(cur_q) + 1'b1));
endmodule

// File: rtl/rdr_wb_fmt.sv
module rdr_wb_fmt
  import rdr_pkg::*;
#(
  parameter int unsigned PLEN_W = 14
) (
  input  wb_kind_e          kind,
  input  logic [1:0]        woff,
  input  logic              fd,
  input  logic              ld,
  input  logic              cda,
  input  logic              es,
  input  logic [PLEN_W-1:0] len,
  input  logic [63:0]       ts,
  output logic [31:0]       word
);
  always_comb begin
    word = '0;
    case (kind)
      WK_BAD: begin
        word[CTX_B] = 1'b1;
        word[FD_B]  = 1'b1;
        word[LD_B]  = 1'b1;
      end
      WK_CTX: begin
        case (woff)
          2'd0:    word = ts[31:0];
          2'd1:    word = ts[63:32];
          default: begin
            word[CTX_B] = 1'b1;
            word[TSA_B] = 1'b1;
          end
        endcase
      end
      default: begin
        word[FD_B]         = fd;
        word[LD_B]         = ld;
        word[CDA_B]        = cda;
        word[ES_B]         = es;
        word[PLEN_W-1:0]   = len;
      end
    endcase
  end
endmodule

// File: rtl/rdr_ring_engine.sv
module rdr_ring_engine
  import rdr_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned IW        = 4,
  parameter int unsigned PLEN_W    = 14,
  parameter int unsigned BUF_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic [AW-1:0]     ring_base,
  input  logic [IW-1:0]     ring_len,
  input  logic [IW-1:0]     tail_idx,
  output logic [IW-1:0]     cur_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              pkt_valid,
  input  logic [PLEN_W-1:0] pkt_len,
  input  logic              pkt_err,
  input  logic              pkt_ts_valid,
  input  logic [63:0]       pkt_ts,
  output logic              pkt_done,
  output logic              buf_valid,
  output logic [AW-1:0]     buf_addr,
  output logic [PLEN_W-1:0] buf_len,
  output logic              irq,
  output logic              no_desc,
  output logic              halted
);
  localparam logic [PLEN_W-1:0] BUF_L = PLEN_W'(BUF_BYTES);

  rdr_state_e        state_q, state_d;
  logic [1:0]        wcnt_q, wcnt_d, woff;
  logic [AW-1:0]     b1_q, b1_d, b2_q, b2_d, slot_addr;
  logic              own_q, own_d, ioc_q, ioc_d, bad_q, bad_d, bsel_q, bsel_d;
  logic              act_q, act_d, first_q, first_d, got_q, got_d, irq_q, irq_d;
  logic [PLEN_W-1:0] rem_q, rem_d, chunk;
  logic              adv, mark_stall, avail, last;
  wb_kind_e          kind;

  rdr_ring_ptr #(.AW(AW), .IW(IW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .ring_base(ring_base),
    .ring_len(ring_len), .tail(tail_idx), .adv(adv), .mark_stall(mark_stall),
    .cur(cur_idx), .slot_addr(slot_addr), .avail(avail));

  assign last  = (rem_q == '0);
  assign chunk = (rem_q > BUF_L) ? BUF_L : rem_q;

  rdr_wb_fmt #(.PLEN_W(PLEN_W)) u_fmt (
    .kind(kind), .woff(woff), .fd(first_q && got_q), .ld(last),
    .cda(last && pkt_ts_valid), .es(last && pkt_err),
    .len(last ? pkt_len : '0), .ts(pkt_ts), .word(mem_wdata));

  always_comb begin
    state_d = state_q; wcnt_d = wcnt_q; b1_d = b1_q; b2_d = b2_q;
    own_d = own_q; ioc_d = ioc_q; bad_d = bad_q; bsel_d = bsel_q;
    act_d = act_q; first_d = first_q; got_d = got_q; rem_d = rem_q;
    irq_d = 1'b0; mem_req = 1'b0; mem_we = 1'b0; woff = wcnt_q;
    kind = WK_NORM; adv = 1'b0; mark_stall = 1'b0; pkt_done = 1'b0;
    buf_valid = 1'b0; buf_addr = bsel_q ? b2_q : b1_q; buf_len = chunk;
    case (state_q)
      S_IDLE: if (pkt_valid && avail) begin
        if (!act_q) begin
          rem_d = pkt_len; first_d = 1'b1; act_d = 1'b1;
        end
        wcnt_d = '0; got_d = 1'b0; state_d = S_FETCH;
      end
      S_FETCH: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          case (wcnt_q)
            2'd0: b1_d = AW'(mem_rdata);
            2'd2: b2_d = AW'(mem_rdata);
            2'd3: begin own_d = mem_rdata[OWN_B]; ioc_d = mem_rdata[IOC_B]; end
            default: ;
          endcase
          wcnt_d = wcnt_q + 1'b1;
          if (wcnt_q == 2'd3) state_d = S_EVAL;
        end
      end
      S_EVAL: begin
        if (!own_q) begin
          mark_stall = 1'b1; state_d = S_IDLE;
        end else if (b1_q == '1 && b2_q == '1) begin
          bad_d = 1'b1; state_d = S_WB;
        end else begin
          bsel_d = 1'b0; state_d = S_DELIV;
        end
      end
      S_DELIV: begin
        if (buf_addr != '0 && !last) begin
          buf_valid = 1'b1; rem_d = rem_q - chunk; got_d = 1'b1;
        end
        bsel_d = 1'b1;
        if (bsel_q) state_d = S_WB;
      end
      S_WB: begin
        mem_req = 1'b1; mem_we = 1'b1; woff = 2'd3;
        kind = bad_q ? WK_BAD : WK_NORM;
        if (mem_ack) begin
          if (bad_q) begin
            pkt_done = 1'b1; act_d = 1'b0; state_d = S_HALT;
          end else begin
            adv = 1'b1; irq_d = ioc_q;
            if (got_q) first_d = 1'b0;
            if (!last)             state_d = S_IDLE;
            else if (pkt_ts_valid) state_d = S_CTXW;
            else begin
              pkt_done = 1'b1; act_d = 1'b0; state_d = S_IDLE;
            end
          end
        end
      end
      S_CTXW: if (avail) begin
        wcnt_d = '0; state_d = S_CTX;
      end
      S_CTX: begin
        mem_req = 1'b1; mem_we = 1'b1; kind = WK_CTX;
        woff = (wcnt_q == 2'd2) ? 2'd3 : wcnt_q;
        if (mem_ack) begin
          wcnt_d = wcnt_q + 1'b1;
          if (wcnt_q == 2'd2) begin
            adv = 1'b1; pkt_done = 1'b1; act_d = 1'b0; state_d = S_IDLE;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; wcnt_q <= '0; b1_q <= '0; b2_q <= '0;
      own_q <= 1'b0; ioc_q <= 1'b0; bad_q <= 1'b0; bsel_q <= 1'b0;
      act_q <= 1'b0; first_q <= 1'b0; got_q <= 1'b0; rem_q <= '0; irq_q <= 1'b0;
    end else if (sw_rst) begin
      state_q <= S_IDLE; wcnt_q <= '0; bad_q <= 1'b0; act_q <= 1'b0;
      got_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      state_q <= state_d; wcnt_q <= wcnt_d; b1_q <= b1_d; b2_q <= b2_d;
      own_q <= own_d; ioc_q <= ioc_d; bad_q <= bad_d; bsel_q <= bsel_d;
      act_q <= act_d; first_q <= first_d; got_q <= got_d; rem_q <= rem_d;
      irq_q <= irq_d;
    end
  end

  assign mem_addr = slot_addr + AW'({woff, 2'b00});
  assign irq      = irq_q;
  assign halted   = (state_q == S_HALT);
  assign no_desc  = ((state_q == S_IDLE && pkt_valid) || state_q == S_CTXW) && !avail;

  // R1: a fetch starts only from a cycle in which a slot was available
  a_r1_fetch_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FETCH && $past(state_q) == S_IDLE) |-> $past(avail));
  // R3: interrupt follows a normal write-back acknowledge
  a_r3_irq_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(state_q == S_WB && mem_ack && !bad_q));
  // R4: no data goes to a zero buffer address
  a_r4_no_zero_buf: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> buf_addr != '0);
  // R5: a stopped engine is silent
  a_r5_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req && !buf_valid && !pkt_done);
  // R6: any word 3 written leaves ownership with software
  a_r6_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[3:2] == 2'b11) |-> !mem_wdata[OWN_B]);
  // R7: context status word carries context and timestamp flags
  a_r7_ctx_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CTX && mem_req && mem_addr[3:2] == 2'b11)
      |-> mem_wdata[CTX_B] && mem_wdata[TSA_B]);
  // R8: each buffer gets between 1 and BUF_BYTES bytes
  a_r8_chunk_limit: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> (buf_len != '0) && (buf_len <= BUF_L));
endmodule

// File: tb/rdr_ring_engine_test.sv
module rdr_ring_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, sw_rst;
  logic [31:0] ring_base;
  logic [3:0]  ring_len, tail_idx, cur_idx;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        pkt_valid, pkt_err, pkt_ts_valid, pkt_done;
  logic [13:0] pkt_len, buf_len;
  logic [63:0] pkt_ts;
  logic        buf_valid, irq, no_desc, halted;
  logic [31:0] buf_addr;

  rdr_ring_engine uut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .ring_base(ring_base),
    .ring_len(ring_len), .tail_idx(tail_idx), .cur_idx(cur_idx),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_err(pkt_err),
    .pkt_ts_valid(pkt_ts_valid), .pkt_ts(pkt_ts), .pkt_done(pkt_done),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_len(buf_len),
    .irq(irq), .no_desc(no_desc), .halted(halted));

  int tests = 0, fails = 0;
  int nbuf = 0, nirq = 0, nreq = 0, bad_addr = 0;
  logic [31:0] dmem [0:63];
  logic [31:0] log_a [0:31];
  logic [13:0] log_l [0:31];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_addr[31:8] != 24'h000001) bad_addr++;
        if (mem_we) dmem[mem_addr[7:2]] = mem_wdata;
        else        mem_rdata <= dmem[mem_addr[7:2]];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (buf_valid && nbuf < 32) begin
        log_a[nbuf] = buf_addr; log_l[nbuf] = buf_len; nbuf++;
      end
      if (irq) nirq++;
      if (mem_req) nreq++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    do begin @(negedge clk); n++; end while (!pkt_done && n < 1000);
    chk({tag, " pkt_done seen"}, 32'(pkt_done), 32'd1);
    pkt_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset mem_req", 32'(mem_req), 0);
    chk("R1 reset halted/irq/no_desc", {29'd0, halted, irq, no_desc}, 0);
    chk("R1 reset cur_idx", 32'(cur_idx), 0);
  endtask

  task automatic t_empty;
    int r0;
    pkt_len = 14'd10; pkt_err = 0; pkt_ts_valid = 0; tail_idx = 4'd0;
    pkt_valid = 1'b1;
    r0 = nreq;
    repeat (20) @(negedge clk);
    chk("R1 empty ring no request", 32'(nreq - r0), 0);
    chk("R1 empty ring no_desc", 32'(no_desc), 1);
    pkt_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_simple;
    int b0 = nbuf, i0 = nirq;
    dmem[0] = 32'h1000; dmem[1] = 0; dmem[2] = 32'h2000; dmem[3] = 32'hC000_0000;
    pkt_len = 14'd100; pkt_err = 0; pkt_ts_valid = 0;
    pkt_valid = 1'b1; tail_idx = 4'd1;
    wait_done("R6 simple");
    chk("R6 simple word3", dmem[3], 32'h3000_0064);
    chk("R10 simple word0 untouched", dmem[0], 32'h1000);
    chk("R8 simple buffer count", 32'(nbuf - b0), 2);
    chk("R8 simple buf1", {log_a[b0][17:0], log_l[b0]}, {18'h01000, 14'd64});
    chk("R8 simple buf2", {log_a[b0+1][17:0], log_l[b0+1]}, {18'h02000, 14'd36});
    chk("R3 simple irq", 32'(nirq - i0), 1);
    chk("R9 simple cur_idx", 32'(cur_idx), 1);
  endtask

  task automatic t_split;
    int b0 = nbuf, i0 = nirq;
    dmem[4] = 0;        dmem[6] = 32'h3000; dmem[7]  = 32'h8000_0000;
    dmem[8] = 32'h4000; dmem[10] = 0;       dmem[11] = 32'hC000_0000;
    pkt_len = 14'd100; pkt_err = 1; pkt_ts_valid = 0;
    pkt_valid = 1'b1; tail_idx = 4'd3;
    wait_done("R8 split");
    chk("R6 split first word3", dmem[7], 32'h2000_0000);
    chk("R6 split last word3", dmem[11], 32'h1000_8064);
    chk("R4 split buffer count", 32'(nbuf - b0), 2);
    chk("R4 split buf a", {log_a[b0][17:0], log_l[b0]}, {18'h03000, 14'd64});
    chk("R8 split buf b", {log_a[b0+1][17:0], log_l[b0+1]}, {18'h04000, 14'd36});
    chk("R3 split irq only on flagged", 32'(nirq - i0), 1);
    chk("R9 split cur_idx", 32'(cur_idx), 3);
  endtask

  task automatic t_own_ctx;
    int b0 = nbuf;
    dmem[12] = 32'h5000; dmem[14] = 32'h6000; dmem[15] = 32'h0;
    dmem[0] = 32'h7000; dmem[2] = 32'hDEAD_BEEF; dmem[3] = 32'h8000_0000;
    pkt_len = 14'd20; pkt_err = 0; pkt_ts_valid = 1; pkt_ts = 64'h1122_3344_5566_7788;
    pkt_valid = 1'b1; tail_idx = 4'd0;
    repeat (40) @(negedge clk);
    chk("R2 not owned no_desc", 32'(no_desc), 1);
    chk("R2 not owned no buffer", 32'(nbuf - b0), 0);
    chk("R2 not owned no write", dmem[15], 0);
    dmem[15] = 32'h8000_0000; tail_idx = 4'd1;
    wait_done("R7 ctx");
    chk("R7 last word3 with spill flag", dmem[15], 32'h3800_0014);
    chk("R7 ctx ts low", dmem[0], 32'h5566_7788);
    chk("R7 ctx ts high", dmem[1], 32'h1122_3344);
    chk("R7 ctx word3", dmem[3], 32'h4000_0010);
    chk("R7 ctx word2 untouched", dmem[2], 32'hDEAD_BEEF);
    chk("R7 ctx one buffer only", 32'(nbuf - b0), 1);
    chk("R2 buffer after release", {log_a[b0][17:0], log_l[b0]}, {18'h05000, 14'd20});
    chk("R9 wrap cur_idx", 32'(cur_idx), 1);
  endtask

  task automatic t_bad;
    int b0 = nbuf, r0;
    dmem[4] = 32'hFFFF_FFFF; dmem[6] = 32'hFFFF_FFFF; dmem[7] = 32'h8000_0000;
    pkt_len = 14'd10; pkt_err = 0; pkt_ts_valid = 0;
    pkt_valid = 1'b1; tail_idx = 4'd2;
    wait_done("R5 bad");
    chk("R5 error word3", dmem[7], 32'h7000_0000);
    chk("R5 halted", 32'(halted), 1);
    chk("R5 no buffer", 32'(nbuf - b0), 0);
    chk("R5 index held", 32'(cur_idx), 1);
    tail_idx = 4'd3; pkt_valid = 1'b1;
    r0 = nreq;
    repeat (20) @(negedge clk);
    chk("R5 silent while halted", 32'(nreq - r0), 0);
    pkt_valid = 1'b0;
    sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0; @(negedge clk);
    chk("R5 released by sw_rst", 32'(halted), 0);
    chk("R5 index cleared", 32'(cur_idx), 0);
    chk("R10 all accesses inside ring", 32'(bad_addr), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    rst_n = 0; sw_rst = 0; ring_base = 32'h100; ring_len = 4'd4; tail_idx = 0;
    pkt_valid = 0; pkt_len = 0; pkt_err = 0; pkt_ts_valid = 0; pkt_ts = 0;
    mem_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_simple();
    t_split();
    t_own_ctx();
    t_bad();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule